// File: doc/BRIEF.md
# Two-Level Cache Tag and Latency Controller

This block models the tag side of a two-level cache hierarchy. It holds only the tags, valid bits and recency stamps of a set-associative first-level store and a larger set-associative second-level store. For each read or write request it reports whether each level hit and how many cycles the access would cost. It also counts accesses and misses per level so that miss rates can be derived. No data is stored, and main memory appears only as a fixed latency.

The fill policy is neither inclusive nor exclusive. A read that misses both levels installs the block in both. A read that misses the first level but hits the second installs it in the first level only. Later evictions in one level never touch the other. Writes go straight through to memory and allocate nothing. Each level keeps its own geometry: blocks = bytes / block size, sets = blocks / ways. Victims are chosen by a global stamp counter that records how recently each way was touched.

A request is taken with a valid/ready handshake. Its result appears as a single-cycle response pulse two clock edges after acceptance. Only one request is in flight at a time.

Top module: `cache2_tagctl`

## Requirements
- R1: Each level splits the address from bit 0 upward. The low log2(block bytes) bits are the byte offset and the next log2(sets) bits are the set index, where sets = (bytes / block bytes) / ways. The remaining high bits are the tag. Addresses that differ only in offset bits fall in the same block.
- R2: A read (`req_write` = 0) that hits the first level responds with `resp_l1_hit` = 1, `resp_l2_hit` = 0 and `resp_cycles` = L1_LAT. The second level is not probed.
- R3: A read that misses the first level and hits the second responds with flags 0/1 and `resp_cycles` = L1_LAT + L2_LAT. The block is installed in the first level, so an immediate re-read hits there.
- R4: A read that misses both levels responds with flags 0/0 and `resp_cycles` = L1_LAT + L2_LAT + MEM_LAT. The block is installed in both levels.
- R5: A write (`req_write` = 1) always responds with `resp_cycles` = L1_LAT + L2_LAT + MEM_LAT. It probes both levels and reports each level's hit flag. A write miss installs nothing in either level.
- R6: A fill uses the lowest-numbered invalid way of the set while one exists. In a full set it replaces the way with the oldest stamp. Any hit (read or write) refreshes that way's stamp in the level that hit. The two levels evict independently, so a block may stay in one level after the other drops it.
- R7: `l1_access_cnt` counts every request and `l1_miss_cnt` counts every first-level miss. `l2_access_cnt` counts every request that probes the second level (a read that missed the first level, or any write). `l2_miss_cnt` counts those probes that miss.
- R8: `req_ready` is high only when no request is in flight, and it is low in the cycle after acceptance. `resp_valid` is high for exactly one cycle, the second cycle after the acceptance edge.
- R9: A synchronous active-high `rst` invalidates every way and clears the stamps and all four counters, so the next read misses both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_l1_hit | output | 1 | First level held the block |
| resp_l2_hit | output | 1 | Second level was probed and held the block |
| resp_cycles | output | LAT_W | Modelled access cost in cycles |
| l1_access_cnt | output | CNT_W | First-level access count |
| l1_miss_cnt | output | CNT_W | First-level miss count |
| l2_access_cnt | output | CNT_W | Second-level access count |
| l2_miss_cnt | output | CNT_W | Second-level miss count |

## Verification
The checker assumes that `req_write` is stable while `req_valid` is high, since it records the operation at the acceptance edge. It also assumes that the latency sum fits in LAT_W and that fewer than 2^STAMP_W requests occur between resets, so neither the latency nor the recency order wraps. It further assumes that the counters never wrap within a run, which its ordering checks between counters rely on. The stimulus keeps to a few dozen requests, holds each request's fields constant until acceptance, and uses default latencies whose sum is 72. Address patterns are chosen so that several blocks share one set in both levels, which drives the recency and independent-eviction cases deterministically.

// File: rtl/c2_pkg.sv
package c2_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOOK = 1'b1
    } c2_state_e;

    typedef enum logic [1:0] {
        OUT_L1  = 2'd0,
        OUT_L2  = 2'd1,
        OUT_MEM = 2'd2
    } c2_outcome_e;

    typedef struct packed {
        logic l1_hit;
        logic l2_hit;
        logic probe_l2;
        logic is_write;
    } c2_probe_t;

    // Where the access was finally served
    function automatic c2_outcome_e c2_classify(c2_probe_t p);
        if (p.is_write)                return OUT_MEM;
        else if (p.l1_hit)             return OUT_L1;
        else if (p.l2_hit)             return OUT_L2;
        else                           return OUT_MEM;
    endfunction

    // Latency summed over the levels the access had to reach
    function automatic int unsigned c2_latency(c2_outcome_e o, int unsigned lat1,
                                               int unsigned lat2, int unsigned latm);
        case (o)
            OUT_L1:  return lat1;
            OUT_L2:  return lat1 + lat2;
            default: return lat1 + lat2 + latm;
        endcase
    endfunction

    function automatic int unsigned c2_idx_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/c2_victim_pick.sv
module c2_victim_pick #(
    parameter int WAYS    = 4,
    parameter int STAMP_W = 16,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]              valid,
    input  logic [WAYS-1:0][STAMP_W-1:0] stamps,
    output logic [WAY_W-1:0]             victim
);

    logic               have_free;
    logic [STAMP_W-1:0] best;

    always_comb begin
        victim    = '0;
        have_free = 1'b0;
        best      = stamps[0];
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !have_free) begin
                have_free = 1'b1;
                victim    = WAY_W'(w);
            end
        end
        if (!have_free) begin
            victim = '0;
            best   = stamps[0];
            for (int w = 1; w < WAYS; w++) begin
                if (stamps[w] < best) begin
                    best   = stamps[w];
                    victim = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/c2_tag_store.sv
module c2_tag_store #(
    parameter int SETS    = 8,
    parameter int WAYS    = 2,
    parameter int IDX_W   = 3,
    parameter int TAG_W   = 9,
    parameter int STAMP_W = 16,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic               upd_en,
    input  logic [WAY_W-1:0]   upd_way,
    input  logic [STAMP_W-1:0] upd_stamp,
    output logic               hit,
    output logic [WAY_W-1:0]   hit_way,
    output logic [WAY_W-1:0]   vict_way
);

    logic [WAYS-1:0]    valid_q [SETS];
    logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
    logic [STAMP_W-1:0] stamp_q [SETS][WAYS];

    logic [WAYS-1:0]              hit_vec;
    logic [WAYS-1:0][STAMP_W-1:0] set_stamps;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w]    = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        assign set_stamps[w] = stamp_q[lk_idx][w];
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    c2_victim_pick #(
        .WAYS    (WAYS),
        .STAMP_W (STAMP_W)
    ) vpick_i (
        .valid  (valid_q[lk_idx]),
        .stamps (set_stamps),
        .victim (vict_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    stamp_q[s][w] <= '0;
                end
            end
        end else if (upd_en) begin
            valid_q[lk_idx][upd_way] <= 1'b1;
            tag_q[lk_idx][upd_way]   <= lk_tag;
            stamp_q[lk_idx][upd_way] <= upd_stamp;
        end
    end

endmodule

// File: rtl/c2_stat_ctr.sv
module c2_stat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + 1'b1;
    end

endmodule

// File: rtl/cache2_tagctl.sv
module cache2_tagctl
    import c2_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int L1_BYTES = 256,
    parameter int L1_BLOCK = 16,
    parameter int L1_WAYS  = 2,
    parameter int L2_BYTES = 1024,
    parameter int L2_BLOCK = 16,
    parameter int L2_WAYS  = 4,
    parameter int L1_LAT   = 2,
    parameter int L2_LAT   = 10,
    parameter int MEM_LAT  = 60,
    parameter int LAT_W    = 8,
    parameter int STAMP_W  = 16,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              resp_valid,
    output logic              resp_l1_hit,
    output logic              resp_l2_hit,
    output logic [LAT_W-1:0]  resp_cycles,
    output logic [CNT_W-1:0]  l1_access_cnt,
    output logic [CNT_W-1:0]  l1_miss_cnt,
    output logic [CNT_W-1:0]  l2_access_cnt,
    output logic [CNT_W-1:0]  l2_miss_cnt
);

    // Geometry of each level
    localparam int L1_BLOCKS = L1_BYTES / L1_BLOCK;
    localparam int L1_SETS   = L1_BLOCKS / L1_WAYS;
    localparam int L1_OFF_W  = $clog2(L1_BLOCK);
    localparam int L1_IDX_W  = c2_idx_bits(L1_SETS);
    localparam int L1_TAG_W  = ADDR_W - L1_OFF_W - L1_IDX_W;
    localparam int L1_WAY_W  = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1;

    localparam int L2_BLOCKS = L2_BYTES / L2_BLOCK;
    localparam int L2_SETS   = L2_BLOCKS / L2_WAYS;
    localparam int L2_OFF_W  = $clog2(L2_BLOCK);
    localparam int L2_IDX_W  = c2_idx_bits(L2_SETS);
    localparam int L2_TAG_W  = ADDR_W - L2_OFF_W - L2_IDX_W;
    localparam int L2_WAY_W  = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1;

    localparam int LO_OFF    = (L1_OFF_W < L2_OFF_W) ? L1_OFF_W : L2_OFF_W;
    localparam int NSTAT     = 4;

    // Request capture
    c2_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic              look;
    logic              offset_unused;

    assign req_ready     = (state_q == ST_IDLE);
    assign look          = (state_q == ST_LOOK);
    assign offset_unused = ^addr_q[LO_OFF-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_LOOK;
                    addr_q  <= req_addr;
                    wr_q    <= req_write;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Recency stamp source
    logic [STAMP_W-1:0] stamp_q;
    logic [STAMP_W-1:0] stamp_next;

    assign stamp_next = stamp_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       stamp_q <= '0;
        else if (look) stamp_q <= stamp_next;
    end

    // First level
    logic [L1_IDX_W-1:0] l1_idx;
    logic [L1_TAG_W-1:0] l1_tag;
    logic                l1_hit;
    logic [L1_WAY_W-1:0] l1_hit_way, l1_vict_way, l1_upd_way;
    logic                l1_upd_en;

    assign l1_idx = addr_q[L1_OFF_W +: L1_IDX_W];
    assign l1_tag = addr_q[ADDR_W-1 -: L1_TAG_W];

    // Second level
    logic [L2_IDX_W-1:0] l2_idx;
    logic [L2_TAG_W-1:0] l2_tag;
    logic                l2_hit;
    logic [L2_WAY_W-1:0] l2_hit_way, l2_vict_way, l2_upd_way;
    logic                l2_upd_en;

    assign l2_idx = addr_q[L2_OFF_W +: L2_IDX_W];
    assign l2_tag = addr_q[ADDR_W-1 -: L2_TAG_W];

    // Probe decision and update policy
    c2_probe_t   probe;
    c2_outcome_e outcome;

    always_comb begin
        probe.l1_hit   = l1_hit;
        probe.l2_hit   = l2_hit;
        probe.is_write = wr_q;
        probe.probe_l2 = wr_q || !l1_hit;
        outcome        = c2_classify(probe);

        // reads fill on miss; every hit refreshes recency; writes never allocate
        l1_upd_en  = look && (l1_hit || !wr_q);
        l1_upd_way = l1_hit ? l1_hit_way : l1_vict_way;
        l2_upd_en  = look && probe.probe_l2 && (l2_hit || !wr_q);
        l2_upd_way = l2_hit ? l2_hit_way : l2_vict_way;
    end

    c2_tag_store #(
        .SETS    (L1_SETS),
        .WAYS    (L1_WAYS),
        .IDX_W   (L1_IDX_W),
        .TAG_W   (L1_TAG_W),
        .STAMP_W (STAMP_W)
    ) l1_store_i (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (l1_idx),
        .lk_tag    (l1_tag),
        .upd_en    (l1_upd_en),
        .upd_way   (l1_upd_way),
        .upd_stamp (stamp_next),
        .hit       (l1_hit),
        .hit_way   (l1_hit_way),
        .vict_way  (l1_vict_way)
    );

    c2_tag_store #(
        .SETS    (L2_SETS),
        .WAYS    (L2_WAYS),
        .IDX_W   (L2_IDX_W),
        .TAG_W   (L2_TAG_W),
        .STAMP_W (STAMP_W)
    ) l2_store_i (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (l2_idx),
        .lk_tag    (l2_tag),
        .upd_en    (l2_upd_en),
        .upd_way   (l2_upd_way),
        .upd_stamp (stamp_next),
        .hit       (l2_hit),
        .hit_way   (l2_hit_way),
        .vict_way  (l2_vict_way)
    );

    // Response register
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_l1_hit <= 1'b0;
            resp_l2_hit <= 1'b0;
            resp_cycles <= '0;
        end else begin
            resp_valid <= look;
            if (look) begin
                resp_l1_hit <= l1_hit;
                resp_l2_hit <= probe.probe_l2 && l2_hit;
                resp_cycles <= LAT_W'(c2_latency(outcome, L1_LAT, L2_LAT, MEM_LAT));
            end
        end
    end

    // Statistics: 0 l1 access, 1 l1 miss, 2 l2 access, 3 l2 miss
    logic [NSTAT-1:0] stat_inc;
    logic [CNT_W-1:0] stat_val [NSTAT];

    assign stat_inc[0] = look;
    assign stat_inc[1] = look && !l1_hit;
    assign stat_inc[2] = look && probe.probe_l2;
    assign stat_inc[3] = look && probe.probe_l2 && !l2_hit;

    for (genvar k = 0; k < NSTAT; k++) begin : g_stat
        c2_stat_ctr #(.W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst   (rst),
            .inc   (stat_inc[k]),
            .count (stat_val[k])
        );
    end

    assign l1_access_cnt = stat_val[0];
    assign l1_miss_cnt   = stat_val[1];
    assign l2_access_cnt = stat_val[2];
    assign l2_miss_cnt   = stat_val[3];

endmodule

// File: rtl/cache2_tagctl_chk.sv
module cache2_tagctl_chk #(
    parameter int L1_LAT  = 2,
    parameter int L2_LAT  = 10,
    parameter int MEM_LAT = 60,
    parameter int LAT_W   = 8,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             resp_valid,
    input logic             resp_l1_hit,
    input logic             resp_l2_hit,
    input logic [LAT_W-1:0] resp_cycles,
    input logic [CNT_W-1:0] l1_access_cnt,
    input logic [CNT_W-1:0] l1_miss_cnt,
    input logic [CNT_W-1:0] l2_access_cnt,
    input logic [CNT_W-1:0] l2_miss_cnt
);

    localparam logic [LAT_W-1:0] C_HIT1 = LAT_W'(L1_LAT);
    localparam logic [LAT_W-1:0] C_HIT2 = LAT_W'(L1_LAT + L2_LAT);
    localparam logic [LAT_W-1:0] C_FULL = LAT_W'(L1_LAT + L2_LAT + MEM_LAT);

    // operation of the request currently being answered
    logic op_wr;
    always_ff @(posedge clk) begin
        if (rst)                         op_wr <= 1'b0;
        else if (req_valid && req_ready) op_wr <= req_write;
    end

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_l1_hit_cost_R2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !op_wr && resp_l1_hit) |-> (resp_cycles == C_HIT1 && !resp_l2_hit));

    assert_l2_hit_cost_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !op_wr && !resp_l1_hit && resp_l2_hit) |-> (resp_cycles == C_HIT2));

    assert_mem_cost_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !op_wr && !resp_l1_hit && !resp_l2_hit) |-> (resp_cycles == C_FULL));

    assert_write_cost_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && op_wr) |-> (resp_cycles == C_FULL));

    assert_miss_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        (l1_miss_cnt <= l1_access_cnt) && (l2_miss_cnt <= l2_access_cnt)
        && (l2_access_cnt <= l1_access_cnt));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (l1_access_cnt == '0 && l1_miss_cnt == '0
                 && l2_access_cnt == '0 && l2_miss_cnt == '0 && !resp_valid));

endmodule

bind cache2_tagctl cache2_tagctl_chk #(
    .L1_LAT  (L1_LAT),
    .L2_LAT  (L2_LAT),
    .MEM_LAT (MEM_LAT),
    .LAT_W   (LAT_W),
    .CNT_W   (CNT_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .resp_valid    (resp_valid),
    .resp_l1_hit   (resp_l1_hit),
    .resp_l2_hit   (resp_l2_hit),
    .resp_cycles   (resp_cycles),
    .l1_access_cnt (l1_access_cnt),
    .l1_miss_cnt   (l1_miss_cnt),
    .l2_access_cnt (l2_access_cnt),
    .l2_miss_cnt   (l2_miss_cnt)
);

// File: tb/cache2_tagctl_tb_top.sv
`timescale 1ns/1ps
module cache2_tagctl_tb_top;

    localparam int HIT1 = 2;
    localparam int HIT2 = 12;
    localparam int FULL = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        resp_valid, resp_l1_hit, resp_l2_hit;
    logic [7:0]  resp_cycles;
    logic [15:0] l1_access_cnt, l1_miss_cnt, l2_access_cnt, l2_miss_cnt;

    always #2 clk = ~clk;

    cache2_tagctl dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .resp_valid    (resp_valid),
        .resp_l1_hit   (resp_l1_hit),
        .resp_l2_hit   (resp_l2_hit),
        .resp_cycles   (resp_cycles),
        .l1_access_cnt (l1_access_cnt),
        .l1_miss_cnt   (l1_miss_cnt),
        .l2_access_cnt (l2_access_cnt),
        .l2_miss_cnt   (l2_miss_cnt)
    );

    typedef struct {
        logic  e1;
        logic  e2;
        int    cyc;
        string rq;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   t_l1a = 0, t_l1m = 0, t_l2a = 0, t_l2m = 0;
    logic prev_resp = 1'b0;

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // Driver: offers one request and pushes its expected result
    task automatic send(input logic [15:0] a, input logic wr, input logic e1,
                        input logic e2, input int cyc, input string rq);
        exp_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        it.e1 = e1; it.e2 = e2; it.cyc = cyc; it.rq = rq;
        exp_q.push_back(it);
        t_l1a++;
        if (!e1) t_l1m++;
        if (wr || !e1) begin
            t_l2a++;
            if (!e2) t_l2m++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_stats(input string rq);
        check(int'(l1_access_cnt) == t_l1a, {rq, " l1 access count"}, int'(l1_access_cnt), t_l1a);
        check(int'(l1_miss_cnt)   == t_l1m, {rq, " l1 miss count"},   int'(l1_miss_cnt),   t_l1m);
        check(int'(l2_access_cnt) == t_l2a, {rq, " l2 access count"}, int'(l2_access_cnt), t_l2a);
        check(int'(l2_miss_cnt)   == t_l2m, {rq, " l2 miss count"},   int'(l2_miss_cnt),   t_l2m);
    endtask

    // Monitor: pops the scoreboard on each response pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (resp_valid) begin
                check(!prev_resp, "R8 single-cycle pulse", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 1, 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(resp_l1_hit == it.e1, {it.rq, " l1 hit"}, int'(resp_l1_hit), int'(it.e1));
                    check(resp_l2_hit == it.e2, {it.rq, " l2 hit"}, int'(resp_l2_hit), int'(it.e2));
                    check(int'(resp_cycles) == it.cyc, {it.rq, " cycles"}, int'(resp_cycles), it.cyc);
                end
            end
            prev_resp <= resp_valid;
        end else begin
            prev_resp <= 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R9 no response after reset", int'(resp_valid), 0);
        check_stats("R9 reset");

        // R4 cold miss, R1/R2 same block by offset, R1 other set
        send(16'h0010, 1'b0, 1'b0, 1'b0, FULL, "R4 cold read");
        send(16'h001F, 1'b0, 1'b1, 1'b0, HIT1, "R1 R2 offset hit");
        send(16'h0020, 1'b0, 1'b0, 1'b0, FULL, "R1 other set miss");

        // R3: push 0x0010 out of first-level set 1, second level keeps it
        send(16'h0090, 1'b0, 1'b0, 1'b0, FULL, "R4 fill set");
        send(16'h0110, 1'b0, 1'b0, 1'b0, FULL, "R6 evict oldest");
        send(16'h0010, 1'b0, 1'b0, 1'b1, HIT2, "R3 l2 hit");
        send(16'h0010, 1'b0, 1'b1, 1'b0, HIT1, "R3 installed in l1");

        // R5 writes
        send(16'h0010, 1'b1, 1'b1, 1'b1, FULL, "R5 write hit");
        send(16'h3000, 1'b1, 1'b0, 1'b0, FULL, "R5 write miss");
        send(16'h3000, 1'b0, 1'b0, 1'b0, FULL, "R5 no write allocate");

        // R6: five blocks sharing set 5 in both levels
        send(16'h4150, 1'b0, 1'b0, 1'b0, FULL, "R6 fill a1");
        send(16'h4250, 1'b0, 1'b0, 1'b0, FULL, "R6 fill a2");
        send(16'h4350, 1'b0, 1'b0, 1'b0, FULL, "R6 fill a3");
        send(16'h4050, 1'b0, 1'b0, 1'b0, FULL, "R6 fill a0");
        send(16'h4150, 1'b1, 1'b0, 1'b1, FULL, "R6 write refresh a1");
        send(16'h4250, 1'b1, 1'b0, 1'b1, FULL, "R6 write refresh a2");
        send(16'h4350, 1'b1, 1'b1, 1'b1, FULL, "R6 write refresh a3");
        send(16'h4050, 1'b0, 1'b1, 1'b0, HIT1, "R6 read refresh a0");
        send(16'h4450, 1'b0, 1'b0, 1'b0, FULL, "R6 a4 evicts per level");
        send(16'h4050, 1'b0, 1'b1, 1'b0, HIT1, "R6 non-inclusive keep");
        send(16'h4350, 1'b0, 1'b0, 1'b1, HIT2, "R6 non-exclusive keep");
        send(16'h4450, 1'b0, 1'b0, 1'b1, HIT2, "R6 l1 victim a4");
        drain();
        check_stats("R7 after traffic");

        // R9 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_l1a = 0; t_l1m = 0; t_l2a = 0; t_l2m = 0;
        check_stats("R9 mid-run reset");
        send(16'h0010, 1'b0, 1'b0, 1'b0, FULL, "R9 tags invalidated");
        send(16'h4050, 1'b1, 1'b0, 1'b0, FULL, "R9 write after reset");
        drain();
        check_stats("R7 R9 after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule